// File: doc/BRIEF.md
# Flash controller status register

This block holds the 32-bit status word of an embedded flash controller. The programming engine, the read path and the option loader outside it report events as single-cycle strobes. The block turns those strobes into sticky flags, tracks whether an operation is in flight, and derives the flags that follow from other flags. Software reads the word and clears flags through a single-cycle port with byte enables. The port answers only at its own offset, with no wait state.

Clearing works by writing one to a flag's bit, and only in byte lanes whose enable is high. A hardware set arriving in the same cycle as a clear beats the clear. A protected-read violation raises an interrupt request when its enable input is high.

Top module: `flash_status_reg`

## Requirements
- R1: After the asynchronous reset, a read at offset 0x10 returns 0x0000_0000 and irq_o is low.
- R2: Flag positions are: 0 done, 1 operation error, 3 program error, 4 write-protect error, 5 alignment error, 6 size error, 7 sequence error, 8 data-miss error, 9 fast-program error, 14 protected-read error, 15 option-invalid, 16 busy. Every other bit reads 0, and writing ones to those bits changes nothing.
- R3: A write at offset 0x10 clears each flag whose data bit is 1 and whose byte lane (be_i[n] covers bits 8n+7..8n) is enabled. Data bits of 0 and disabled lanes leave flags unchanged.
- R4: When a hardware set and a write-one clear hit the same flag in the same cycle, the flag is 1 afterwards.
- R5: Busy rises the cycle after op_start_i. It falls the cycle after op_done_i or any error strobe, unless op_start_i is also high. Writes never change it.
- R6: op_done_i sets the done flag, and op_err_i sets the operation-error flag.
- R7: While fast_en_i is high, an alignment, size, write-protect or data-miss strobe sets the fast-program error flag in the same cycle as its own flag. With fast_en_i low, only the strobe's own flag is set.
- R8: flash_wr_i with both pg_en_i and fast_en_i low sets the sequence-error flag.
- R9: flash_wr_i sets the sequence-error flag while any of the program, size, alignment, write-protect, data-miss or fast-program flags is already set.
- R10: prot_rd_i sets the protected-read flag. irq_o is high exactly while that flag is set and rd_irq_en_i is high.
- R11: While opt_bad_i is high, the option-invalid flag is set every cycle, also right after a reset, so a clear does not stick.
- R12: Writes at any other offset change nothing, and reads at any other offset or with rd_en_i low return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register offset of the access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data, ones clear flags |
| rdata_o | output | 32 | Read data, combinational, same cycle |
| op_start_i | input | 1 | Flash operation begins |
| op_done_i | input | 1 | Flash operation completed |
| op_err_i | input | 1 | Operation error strobe |
| prog_err_i | input | 1 | Program error strobe |
| wprot_err_i | input | 1 | Write-protect error strobe |
| align_err_i | input | 1 | Alignment error strobe |
| size_err_i | input | 1 | Size error strobe |
| miss_err_i | input | 1 | Fast-program data-miss strobe |
| pg_en_i | input | 1 | Normal programming enabled |
| fast_en_i | input | 1 | Fast programming enabled or in progress |
| flash_wr_i | input | 1 | A write to the flash array arrives |
| prot_rd_i | input | 1 | Data read hit a read-protected region |
| rd_irq_en_i | input | 1 | Interrupt enable for protected reads |
| opt_bad_i | input | 1 | Loaded options are not valid |
| irq_o | output | 1 | Protected-read interrupt request |

## Verification
The bench clears single flags through one byte lane and then through two lanes. A design that ignored be_i would wipe flags in lanes that were disabled. A design that decoded lanes wrongly would leave the target flag set. It fires an alignment error in the same cycle as a clear of that bit, which catches a design that gives the clear priority. It checks the sequence error both with no enable and with a pending error. This catches a dropped dependency, and it also catches a design that raises the flag on every flash write. Writes of all ones to reserved bits and to another offset must leave a set flag and the read data untouched. A clear while opt_bad_i is held, and a reset with opt_bad_i held, must both leave the option-invalid flag set.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  localparam int BIT_DONE  = 0;
  localparam int BIT_OPER  = 1;
  localparam int BIT_PROG  = 3;
  localparam int BIT_WPROT = 4;
  localparam int BIT_ALIGN = 5;
  localparam int BIT_SIZE  = 6;
  localparam int BIT_SEQ   = 7;
  localparam int BIT_MISS  = 8;
  localparam int BIT_FAST  = 9;
  localparam int BIT_PRD   = 14;
  localparam int BIT_OPTV  = 15;
  localparam int BIT_BUSY  = 16;

  // flags cleared by writing one
  localparam logic [DATA_W-1:0] W1C_MASK =
      (DATA_W'(1) << BIT_DONE)  | (DATA_W'(1) << BIT_OPER)  |
      (DATA_W'(1) << BIT_PROG)  | (DATA_W'(1) << BIT_WPROT) |
      (DATA_W'(1) << BIT_ALIGN) | (DATA_W'(1) << BIT_SIZE)  |
      (DATA_W'(1) << BIT_SEQ)   | (DATA_W'(1) << BIT_MISS)  |
      (DATA_W'(1) << BIT_FAST)  | (DATA_W'(1) << BIT_PRD)   |
      (DATA_W'(1) << BIT_OPTV);

  localparam logic [DATA_W-1:0] RD_MASK = W1C_MASK | (DATA_W'(1) << BIT_BUSY);

  // errors that make a later flash write a sequence error
  localparam logic [DATA_W-1:0] PEND_MASK =
      (DATA_W'(1) << BIT_PROG)  | (DATA_W'(1) << BIT_SIZE)  |
      (DATA_W'(1) << BIT_ALIGN) | (DATA_W'(1) << BIT_WPROT) |
      (DATA_W'(1) << BIT_MISS)  | (DATA_W'(1) << BIT_FAST);

  typedef struct packed {
    logic op_done;
    logic op_err;
    logic prog_err;
    logic wprot_err;
    logic align_err;
    logic size_err;
    logic miss_err;
    logic flash_wr;
    logic prot_rd;
    logic opt_bad;
  } sr_ev_t;
endpackage

// File: rtl/flash_sr_set_logic.sv
module flash_sr_set_logic
  import flash_sr_pkg::*;
(
  input  sr_ev_t              ev_i,
  input  logic                pg_en_i,
  input  logic                fast_en_i,
  input  logic [DATA_W-1:0]   flags_i,
  output logic [DATA_W-1:0]   set_o
);
  logic pending;
  logic fast_abort;
  logic seq_err;

  assign pending    = |(flags_i & PEND_MASK);
  assign fast_abort = fast_en_i &
                      (ev_i.align_err | ev_i.size_err | ev_i.wprot_err | ev_i.miss_err);
  assign seq_err    = ev_i.flash_wr & (~(pg_en_i | fast_en_i) | pending);

  always_comb begin
    set_o            = '0;
    set_o[BIT_DONE]  = ev_i.op_done;
    set_o[BIT_OPER]  = ev_i.op_err;
    set_o[BIT_PROG]  = ev_i.prog_err;
    set_o[BIT_WPROT] = ev_i.wprot_err;
    set_o[BIT_ALIGN] = ev_i.align_err;
    set_o[BIT_SIZE]  = ev_i.size_err;
    set_o[BIT_SEQ]   = seq_err;
    set_o[BIT_MISS]  = ev_i.miss_err;
    set_o[BIT_FAST]  = fast_abort;
    set_o[BIT_PRD]   = ev_i.prot_rd;
    set_o[BIT_OPTV]  = ev_i.opt_bad;
  end
endmodule

// File: rtl/flash_sr_bus.sv
module flash_sr_bus
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int REG_OFFSET = 'h10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] status_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

  logic [DATA_W-1:0] lane_m;

  for (genvar l = 0; l < BE_W; l++) begin : g_lane
    assign lane_m[l*8 +: 8] = {8{be_i[l]}};
  end

  assign hit_o   = (addr_i == OFFS);
  assign clr_o   = (wr_en_i && hit_o) ? (wdata_i & lane_m & W1C_MASK) : '0;
  assign rdata_o = (rd_en_i && hit_o) ? (status_i & RD_MASK) : '0;
endmodule

// File: rtl/flash_sr_flags.sv
module flash_sr_flags
  import flash_sr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic [DATA_W-1:0] clr_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q;

  // set dominates clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= ((q & ~clr_i) | set_i) & W1C_MASK;
  end

  assign q_o = q;

  for (genvar k = 0; k < DATA_W; k++) begin : g_chk
    if (W1C_MASK[k]) begin : g_w1c
      a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[k] |=> q[k]);
      a_r3_clear_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i[k] && !set_i[k]) |=> !q[k]);
      a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i[k] && !set_i[k]) |=> q[k] == $past(q[k]));
    end else begin : g_rsv
      a_r2_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !q[k]);
    end
  end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg
  import flash_sr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int REG_OFFSET = 'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [3:0]        be_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              op_start_i,
  input  logic              op_done_i,
  input  logic              op_err_i,
  input  logic              prog_err_i,
  input  logic              wprot_err_i,
  input  logic              align_err_i,
  input  logic              size_err_i,
  input  logic              miss_err_i,
  input  logic              pg_en_i,
  input  logic              fast_en_i,
  input  logic              flash_wr_i,
  input  logic              prot_rd_i,
  input  logic              rd_irq_en_i,
  input  logic              opt_bad_i,
  output logic              irq_o
);
  sr_ev_t            ev;
  logic [DATA_W-1:0] flags_q;
  logic [DATA_W-1:0] set_v;
  logic [DATA_W-1:0] clr_v;
  logic [DATA_W-1:0] status;
  logic              hit;
  logic              busy_q;
  logic              op_end;

  assign ev = '{op_done:   op_done_i,
                op_err:    op_err_i,
                prog_err:  prog_err_i,
                wprot_err: wprot_err_i,
                align_err: align_err_i,
                size_err:  size_err_i,
                miss_err:  miss_err_i,
                flash_wr:  flash_wr_i,
                prot_rd:   prot_rd_i,
                opt_bad:   opt_bad_i};

  flash_sr_set_logic i_set (
    .ev_i      (ev),
    .pg_en_i   (pg_en_i),
    .fast_en_i (fast_en_i),
    .flags_i   (flags_q),
    .set_o     (set_v)
  );

  flash_sr_flags i_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_v),
    .clr_i  (clr_v),
    .q_o    (flags_q)
  );

  // busy: a new start overrides a finish in the same cycle
  assign op_end = op_done_i | op_err_i | prog_err_i | wprot_err_i |
                  align_err_i | size_err_i | miss_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= op_start_i | (busy_q & ~op_end);
  end

  always_comb begin
    status           = flags_q;
    status[BIT_BUSY] = busy_q;
  end

  flash_sr_bus #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
  ) i_bus (
    .addr_i   (addr_i),
    .wr_en_i  (wr_en_i),
    .rd_en_i  (rd_en_i),
    .be_i     (be_i),
    .wdata_i  (wdata_i),
    .status_i (status),
    .hit_o    (hit),
    .clr_o    (clr_v),
    .rdata_o  (rdata_o)
  );

  assign irq_o = flags_q[BIT_PRD] & rd_irq_en_i;

  a_r5_busy_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_i |=> rdata_o[BIT_BUSY] || !(rd_en_i && hit));
  a_r5_busy_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_end && !op_start_i) |=> !busy_q);
  a_r7_fast_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_en_i && (align_err_i || miss_err_i)) |=> flags_q[BIT_FAST]);
  a_r9_seq_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flash_wr_i && (flags_q & PEND_MASK) != '0) |=> flags_q[BIT_SEQ]);
  a_r10_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prot_rd_i && rd_irq_en_i) ##1 rd_irq_en_i |-> irq_o);
  a_r11_opt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opt_bad_i |=> flags_q[BIT_OPTV]);
  a_r12_miss_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !hit && set_v == '0) |=> $stable(flags_q));
  a_r2_rsv_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~RD_MASK) == '0);
endmodule

// File: tb/test_flash_status_reg.sv
module test_flash_status_reg;
  localparam int B_DONE = 0, B_OPER = 1, B_PROG = 3, B_ALIGN = 5,
                 B_SEQ = 7, B_MISS = 8, B_FAST = 9, B_PRD = 14, B_OPTV = 15,
                 B_BUSY = 16;
  localparam logic [7:0] OFFS = 8'h10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] addr_i = OFFS;
  logic wr_en_i = 0, rd_en_i = 0;
  logic [3:0] be_i = 4'h0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic op_start_i = 0, op_done_i = 0, op_err_i = 0, prog_err_i = 0;
  logic wprot_err_i = 0, align_err_i = 0, size_err_i = 0, miss_err_i = 0;
  logic pg_en_i = 0, fast_en_i = 0, flash_wr_i = 0, prot_rd_i = 0;
  logic rd_irq_en_i = 0, opt_bad_i = 0;
  logic irq_o;

  int n_chk = 0, n_err = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk_i = ~clk_i;

  flash_status_reg i_flash_status_reg (.*);

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    addr_i = a; rd_en_i = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    step();
    rd_en_i = 1'b0; addr_i = OFFS;
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    addr_i = a; be_i = be; wdata_i = d; wr_en_i = 1'b1;
    step();
    wr_en_i = 1'b0; be_i = 4'h0; wdata_i = '0; addr_i = OFFS;
  endtask

  task automatic clr_all();
    wr(OFFS, 4'hF, 32'hFFFF_FFFF);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    n_chk++;
    if (irq_o !== exp) begin
      n_err++;
      $display("FAIL %s irq_o actual=%0b expected=%0b", tag, irq_o, exp);
    end
  endtask

  // monitor: compare read data in the middle of the cycle
  always @(negedge clk_i) begin
    if (rd_en_i) begin
      logic [31:0] e;
      string t;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_err++;
        $display("FAIL scoreboard empty actual=%h expected=none", rdata_o);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata_o !== e) begin
          n_err++;
          $display("FAIL %s rdata actual=%h expected=%h", t, rdata_o, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    rd(OFFS, 32'h0, "R1 reset value");
    chk_irq(1'b0, "R1 irq after reset");

    // busy and done
    op_start_i = 1; step(); op_start_i = 0;
    rd(OFFS, 32'h1 << B_BUSY, "R5 busy after start");
    clr_all();
    rd(OFFS, 32'h1 << B_BUSY, "R5 write leaves busy");
    op_done_i = 1; step(); op_done_i = 0;
    rd(OFFS, 32'h1 << B_DONE, "R6 done sets flag, R5 busy falls");

    // byte-lane clears
    wr(OFFS, 4'b0010, 32'h0000_0001);
    rd(OFFS, 32'h1 << B_DONE, "R3 disabled lane keeps flag");
    wr(OFFS, 4'hF, 32'h0);
    rd(OFFS, 32'h1 << B_DONE, "R3 zero data keeps flag");
    wr(OFFS, 4'b0001, 32'h0000_0001);
    rd(OFFS, 32'h0, "R3 enabled lane clears");

    // error ends busy, then a pending-error flash write
    op_start_i = 1; step(); op_start_i = 0;
    prog_err_i = 1; op_err_i = 1; step(); prog_err_i = 0; op_err_i = 0;
    rd(OFFS, (32'h1 << B_PROG) | (32'h1 << B_OPER), "R5 error ends busy, R6 op error");
    pg_en_i = 1; flash_wr_i = 1; step(); flash_wr_i = 0;
    rd(OFFS, (32'h1 << B_PROG) | (32'h1 << B_OPER) | (32'h1 << B_SEQ), "R9 pending error");
    clr_all();
    rd(OFFS, 32'h0, "R3 clear all");
    flash_wr_i = 1; step(); flash_wr_i = 0;
    rd(OFFS, 32'h0, "R8 enabled write no seq error");
    pg_en_i = 0;
    flash_wr_i = 1; step(); flash_wr_i = 0;
    rd(OFFS, 32'h1 << B_SEQ, "R8 write without enable");
    clr_all();

    // fast-program abort
    fast_en_i = 1; miss_err_i = 1; step(); miss_err_i = 0; fast_en_i = 0;
    rd(OFFS, (32'h1 << B_MISS) | (32'h1 << B_FAST), "R7 miss in fast mode");
    wr(OFFS, 4'b0011, 32'h0000_0300);
    rd(OFFS, 32'h0, "R3 half-word clear");
    align_err_i = 1; step(); align_err_i = 0;
    rd(OFFS, 32'h1 << B_ALIGN, "R7 no fast flag outside fast mode");

    // set beats clear
    align_err_i = 1; addr_i = OFFS; be_i = 4'b0001; wdata_i = 32'h1 << B_ALIGN;
    wr_en_i = 1; step();
    align_err_i = 0; wr_en_i = 0; be_i = 0; wdata_i = 0;
    rd(OFFS, 32'h1 << B_ALIGN, "R4 set wins over clear");
    clr_all();

    // protected read and interrupt
    prot_rd_i = 1; step(); prot_rd_i = 0;
    chk_irq(1'b0, "R10 irq masked");
    rd_irq_en_i = 1; #1;
    chk_irq(1'b1, "R10 irq enabled");
    rd(OFFS, 32'h1 << B_PRD, "R10 protected read flag");
    wr(OFFS, 4'b0010, 32'h1 << B_PRD);
    chk_irq(1'b0, "R10 irq drops after clear");
    rd_irq_en_i = 0;

    // option-invalid
    opt_bad_i = 1; step();
    clr_all();
    rd(OFFS, 32'h1 << B_OPTV, "R11 clear does not stick");
    rst_ni = 0; step(); step(); rst_ni = 1; step();
    rd(OFFS, 32'h1 << B_OPTV, "R11 set again after reset");
    opt_bad_i = 0; step();
    clr_all();
    rd(OFFS, 32'h0, "R11 clears once input drops");

    // reserved bits and foreign offsets
    op_done_i = 1; step(); op_done_i = 0;
    wr(OFFS, 4'hF, 32'hFFFF_FFFF & ~32'h0000_C3FB);
    rd(OFFS, 32'h1 << B_DONE, "R2 reserved writes ignored");
    wr(8'h14, 4'hF, 32'hFFFF_FFFF);
    rd(OFFS, 32'h1 << B_DONE, "R12 other offset write ignored");
    rd(8'h14, 32'h0, "R12 other offset reads zero");

    repeat (2) step();
    n_chk++;
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule